// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by an integer N = P*B + A. It does this with three parts. A synchronous prescaler divides either by P or by P+1. A main counter B counts the prescaler periods in one output cycle. A swallow counter A decides how many of those periods use the longer modulus. Because the prescaler can switch modulus partway through a cycle, every integer from P*(P-1) upward can be reached, not only multiples of P.

At each cycle boundary, both counters load their programmed values and the prescaler starts in the long modulus. Once the swallow count runs out, the prescaler switches to the short modulus for the rest of the cycle. When the main count expires, the block emits a one-clock output pulse and starts a new cycle. A and B settings, and the choice of lower modulus, are sampled only at that boundary. A setting that cannot be realised is refused: the block keeps running on the last accepted setting and raises an error flag.

Top module: `psd_divider`

## Requirements
- R1: In steady state, `pulse_o` is high for exactly one clock in every P*B + A clocks, where P, A and B are the accepted setting for that cycle.
- R2: The lower prescaler modulus P is 8 when `psel_i` is 0 and 16 when `psel_i` is 1.
- R3: `mod_o` is 1 while the prescaler divides by P+1 and 0 while it divides by P. In each cycle, `mod_o` is high for the first A prescaler periods, which is exactly A*(P+1) clocks, and low for the remaining B-A periods.
- R4: A setting is accepted when 3 <= B <= 4095 and A <= B, with A ranging over 0..63. This includes A = 0 (N = P*B) and A = B (every period uses the long modulus).
- R5: If B < 3 or A > B when a boundary is reached, the previous accepted A, B and P stay in effect, and `err_o` becomes 1 from that boundary on. The next boundary that sees a legal setting clears `err_o` and adopts that setting.
- R6: `a_i`, `b_i` and `psel_i` are sampled only at a cycle boundary. A change made inside a cycle does not alter that cycle's length and takes effect in the following cycle.
- R7: While reset is asserted, and just after it, `pulse_o`, `mod_o` and `err_o` are 0. The block then starts with P = 8, A = 0, B = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| psel_i | input | 1 | Lower modulus select: 0 gives P=8, 1 gives P=16 |
| a_i | input | 6 | Programmed swallow count A |
| b_i | input | 12 | Programmed main count B |
| pulse_o | output | 1 | One-clock pulse per divided cycle |
| mod_o | output | 1 | Prescaler modulus control, 1 selects P+1 |
| err_o | output | 1 | Last sampled setting was refused |

## Verification
The bench builds the block with its default parameters: 6-bit A, 12-bit B, and lower moduli of 8 and 16. This puts every corner of the counters within reach, including N = 24, A = B = 63, and the largest N of 32823 with P = 8. Randomized legal settings with small B cover both moduli quickly. Directed cases cover refused settings, recovery from them, and a setting changed partway through a cycle. For each interval the bench counts both the clocks between pulses and the clocks with `mod_o` high.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int A_W   = 6;
    localparam int B_W   = 12;
    localparam int P_LO  = 8;
    localparam int P_HI  = 16;
    localparam int PC_W  = $clog2(P_HI + 2);
    localparam int B_MIN = 3;
    localparam int A_RST = 0;
    localparam int B_RST = 3;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           psel;
        logic           err;
    } cfg_t;

    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
        logic           pulse;
    } swc_t;

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } psc_t;
endpackage

// File: rtl/psd_cfg.sv
module psd_cfg
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           boundary,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           psel_in,
    output logic [A_W-1:0] nxt_a,
    output logic [B_W-1:0] nxt_b,
    output logic           act_psel,
    output logic           err
);
    cfg_t cfg_d, cfg_q;
    logic legal;

    always_comb begin
        legal = (b_in >= B_W'(B_MIN)) && (B_W'(a_in) <= b_in);
        nxt_a = legal ? a_in : cfg_q.a;
        nxt_b = legal ? b_in : cfg_q.b;
        cfg_d = cfg_q;
        if (boundary) begin
            if (legal) begin
                cfg_d.a    = a_in;
                cfg_d.b    = b_in;
                cfg_d.psel = psel_in;
                cfg_d.err  = 1'b0;
            end else begin
                cfg_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.a    <= A_W'(A_RST);
            cfg_q.b    <= B_W'(B_RST);
            cfg_q.psel <= 1'b0;
            cfg_q.err  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act_psel = cfg_q.psel;
    assign err      = cfg_q.err;

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.b >= B_W'(B_MIN)) && (B_W'(cfg_q.a) <= cfg_q.b)); // R4
    AST_HOLD_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && !legal |=> $stable(cfg_q.a) && $stable(cfg_q.b) && $stable(cfg_q.psel) && cfg_q.err); // R5
    AST_NO_MIDCYCLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(cfg_q)); // R6
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int P_LOW  = P_LO,
    parameter int P_HIGH = P_HI
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_hi,
    input  logic mod,
    output logic tick
);
    localparam int CW = $clog2(P_HIGH + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [CW-1:0] len;

    always_comb begin
        len   = sel_hi ? CW'(P_HIGH) : CW'(P_LOW);
        len   = len + CW'(mod);
        tick  = (pre_q.cnt == len - CW'(1));
        pre_d = pre_q;
        if (tick) pre_d.cnt = '0;
        else      pre_d.cnt = pre_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q.cnt <= '0;
        else        pre_q     <= pre_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q.cnt < len); // R3
    AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pre_q.cnt == '0); // R1
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [A_W-1:0] ld_a,
    input  logic [B_W-1:0] ld_b,
    output logic           boundary,
    output logic           pulse,
    output logic           mod
);
    swc_t sw_d, sw_q;

    always_comb begin
        boundary = tick && (sw_q.b_cnt == B_W'(1));
        sw_d       = sw_q;
        sw_d.pulse = 1'b0;
        if (boundary) begin
            sw_d.a_cnt = ld_a;
            sw_d.b_cnt = ld_b;
            sw_d.pulse = 1'b1;
        end else if (tick) begin
            sw_d.b_cnt = sw_q.b_cnt - B_W'(1);
            if (sw_q.a_cnt != '0) sw_d.a_cnt = sw_q.a_cnt - A_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q.a_cnt <= A_W'(A_RST);
            sw_q.b_cnt <= B_W'(B_RST);
            sw_q.pulse <= 1'b0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign pulse = sw_q.pulse;
    assign mod   = (sw_q.a_cnt != '0);

    AST_B_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q.b_cnt != '0); // R1
    AST_A_WITHIN_B: assert property (@(posedge clk) disable iff (!rst_n)
        B_W'(sw_q.a_cnt) <= sw_q.b_cnt); // R4
    AST_MOD_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mod)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R1
endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psel_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           pulse_o,
    output logic           mod_o,
    output logic           err_o
);
    logic           tick;
    logic           boundary;
    logic           act_psel;
    logic [A_W-1:0] nxt_a;
    logic [B_W-1:0] nxt_b;

    psd_prescaler #(.P_LOW(P_LO), .P_HIGH(P_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel_hi(act_psel), .mod(mod_o), .tick(tick)
    );

    psd_swallow u_sw (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_a(nxt_a), .ld_b(nxt_b),
        .boundary(boundary), .pulse(pulse_o), .mod(mod_o)
    );

    psd_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .a_in(a_i), .b_in(b_i),
        .psel_in(psel_i), .nxt_a(nxt_a), .nxt_b(nxt_b), .act_psel(act_psel),
        .err(err_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !pulse_o && !err_o); // R7
endmodule

// File: tb/sim_psd_divider.sv
module sim_psd_divider;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel_i = 1'b0;
    logic [5:0]  a_i = '0;
    logic [11:0] b_i = 12'd3;
    logic        pulse_o, mod_o, err_o;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psd_divider u0 (.clk(clk), .rst_n(rst_n), .psel_i(psel_i), .a_i(a_i), .b_i(b_i),
                    .pulse_o(pulse_o), .mod_o(mod_o), .err_o(err_o));

    function automatic int exp_n(input bit ps, input int a, input int b);
        return (ps ? 16 : 8) * b + a;
    endfunction

    function automatic int exp_hi(input bit ps, input int a);
        return a * ((ps ? 16 : 8) + 1);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_pulse();
        @(negedge clk);
        while (!pulse_o) @(negedge clk);
    endtask

    task automatic measure(output int n, output int hi);
        n = 0; hi = 0;
        do begin
            if (mod_o) hi++;
            n++;
            @(negedge clk);
        end while (!pulse_o);
    endtask

    // drive a setting, expect (eps, ea, eb) to be the one in force
    task automatic apply(input bit ps, input int a, input int b,
                         input bit eps, input int ea, input int eb,
                         input bit eerr, input string req);
        int n, hi;
        psel_i = ps; a_i = 6'(a); b_i = 12'(b);
        wait_pulse();
        check({req, " err flag"}, int'(err_o), int'(eerr));
        measure(n, hi);
        check({req, " R1 period"}, n, exp_n(eps, ea, eb));
        check({req, " R3 mod-high clocks"}, hi, exp_hi(eps, ea));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, hi;
        repeat (3) @(negedge clk);
        check("R7 pulse in reset", int'(pulse_o), 0);
        check("R7 mod in reset", int'(mod_o), 0);
        check("R7 err in reset", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 err after reset", int'(err_o), 0);

        apply(0, 0, 3, 0, 0, 3, 0, "R4 min B A=0");
        apply(1, 5, 10, 1, 5, 10, 0, "R2 P=16");
        apply(0, 5, 10, 0, 5, 10, 0, "R2 P=8");
        apply(0, 63, 63, 0, 63, 63, 0, "R4 A=B");
        apply(1, 20, 3, 0, 63, 63, 1, "R5 A>B refused");
        apply(1, 0, 2, 0, 63, 63, 1, "R5 B<3 refused");
        apply(1, 7, 9, 1, 7, 9, 0, "R5 recovery");
        apply(0, 63, 4095, 0, 63, 4095, 0, "R4 max B");

        // R6: change inside a cycle
        apply(0, 2, 5, 0, 2, 5, 0, "R6 setup");
        n = 0; hi = 0;
        do begin
            if (n == 5) begin psel_i = 1'b1; a_i = 6'd1; b_i = 12'd4; end
            n++;
            @(negedge clk);
        end while (!pulse_o);
        check("R6 current cycle unchanged", n, exp_n(0, 2, 5));
        measure(n, hi);
        check("R6 next cycle uses new setting", n, exp_n(1, 1, 4));
        check("R6 R3 mod-high", hi, exp_hi(1, 1));

        // constrained random legal settings
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin
            bit ps;
            int b, a, amax;
            ps = 1'($urandom_range(0, 1));
            b  = $urandom_range(3, 40);
            amax = (b < 63) ? b : 63;
            a  = $urandom_range(0, amax);
            apply(ps, a, b, ps, a, b, 0, "R1 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule